// File: doc/BRIEF.md
# Interrupt and DMA Request Register Bank

This block is the register-level control point for a serial infrared peripheral. It holds eight interrupt status bits. Software sets them through a write-one-to-set register and clears them through a write-one-to-clear register. Single-cycle event pulses from the peripheral's datapath can also set them. A single interrupt line goes high whenever any status bit is set.

The same bank has a read/write DMA enable register with four bits. Each bit gates one hardware DMA request line. A request pulse that arrives while its channel is enabled is latched as pending and driven to the DMA engine. It stays pending until the engine acknowledges it or software writes a 0 to that enable bit. Writing the 0 also cancels the pending request.

Access is through a simple synchronous register bus with a word address, a write strobe, write data and registered read data. Register words: 0 = status (read-only), 1 = set (write-only), 2 = clear (write-only), 3 = DMA enable (read/write).

Top module: `irda_irq_dma_regs`

## Requirements
- R1: After reset, all interrupt status bits and DMA enable bits are 0. irq_o is 0 and dma_req_o is 0.
- R2: A write to word 1 sets every status bit whose write-data bit is 1. Bits written 0 keep their value. Word 0 returns the status in bits [7:0], with bit 0 last single request, 1 single request, 2 last burst request, 3 burst request, 4 frame transmitted, 5 signal detected, 6 frame invalid and 7 frame detected. Bits [31:8] of word 0 read 0.
- R3: A write to word 2 clears every status bit whose write-data bit is 1. Bits written 0 keep their value.
- R4: A 1 on irq_evt_i[i] at a clock edge sets status bit i.
- R5: When a set (from a hardware event or a software set write) and a software clear hit the same status bit on the same edge, the bit ends up set.
- R6: irq_o is 1 exactly when at least one of the eight status bits is 1.
- R7: Words 1 and 2 always read as 0.
- R8: Word 3 holds the four DMA enables in bits [3:0]: bit 3 burst request, bit 2 last burst request, bit 1 single request, bit 0 last single request. A read returns the current enables. Writes to bits [31:4] are ignored, and those bits read 0.
- R9: A 1 on dma_req_i[i] at an edge where enable i was already 1 before that edge makes dma_req_o[i] go high. It stays high until it is acknowledged or disabled.
- R10: A 1 on dma_ack_i[i] clears pending request i. If a new enabled request arrives on the same edge, the request wins.
- R11: Writing 0 to enable bit i clears pending request i and blocks any later request until the bit is written 1 again. Writing 1 to an enable bit leaves its pending request unchanged.
- R12: rdata_o is registered. The word selected by addr_i at an edge appears after that edge and shows the state from before that edge. Unmapped words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 4 | Register word address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_evt_i | input | 8 | Hardware interrupt event pulses |
| irq_o | output | 1 | Combined interrupt line |
| dma_req_i | input | 4 | Hardware DMA request pulses |
| dma_ack_i | input | 4 | DMA acknowledges from the engine |
| dma_req_o | output | 4 | Pending DMA requests |

## Verification
Status bits, enable bits and pending requests all change on the edge that samples the stimulus. irq_o and dma_req_o settle right after that edge. rdata_o shows the addressed word as it stood before the same edge. The bench therefore drives all inputs on a falling edge. It reads irq_o and dma_req_o on the next falling edge. For register contents it presents the address one falling edge after a write and samples rdata_o on the falling edge after that, so one rising edge lies between each stimulus and its sample. A read issued in the same cycle as an event pulse is also checked to return the pre-event value.

// File: rtl/irda_regbank_pkg.sv
package irda_regbank_pkg;
  localparam int unsigned N_IRQ = 8;
  localparam int unsigned N_DMA = 4;

  typedef enum logic [1:0] {
    REG_STATUS = 2'd0,
    REG_SET    = 2'd1,
    REG_CLR    = 2'd2,
    REG_DMA    = 2'd3
  } reg_sel_e;

  // status bit positions
  localparam int unsigned IRQ_LSREQ  = 0;
  localparam int unsigned IRQ_SREQ   = 1;
  localparam int unsigned IRQ_LBREQ  = 2;
  localparam int unsigned IRQ_BREQ   = 3;
  localparam int unsigned IRQ_FTX    = 4;
  localparam int unsigned IRQ_SIGDET = 5;
  localparam int unsigned IRQ_FINV   = 6;
  localparam int unsigned IRQ_FDET   = 7;
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] status_o
);
  logic [N-1:0] status_q;

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_i) | set_i;
  end

  assign status_o = status_q;

  for (genvar i = 0; i < N; i++) begin : g_chk
    a_r5_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> status_q[i]);
    a_r3_clear_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !set_i[i]) |=> !status_q[i]);
    a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i[i] && !set_i[i]) |=> $stable(status_q[i]));
  end
endmodule

// File: rtl/dma_req_chan.sv
module dma_req_chan (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_wr_i,
  input  logic en_wdata_i,
  input  logic req_i,
  input  logic ack_i,
  output logic en_o,
  output logic pend_o
);
  logic en_q, pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= 1'b0;
    else if (en_wr_i) en_q <= en_wdata_i;
  end

  // disable write cancels; enabled request beats ack
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      pend_q <= 1'b0;
    else if (en_wr_i && !en_wdata_i)  pend_q <= 1'b0;
    else if (en_q && req_i)           pend_q <= 1'b1;
    else if (ack_i)                   pend_q <= 1'b0;
  end

  assign en_o   = en_q;
  assign pend_o = pend_q;

  a_r11_drop_on_disable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_wr_i && !en_wdata_i) |=> !pend_q);
  a_r11_idle_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> !pend_q);
  a_r9_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && req_i && !(en_wr_i && !en_wdata_i)) |=> pend_q);
  a_r10_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !req_i && !en_wr_i) |=> !pend_q);
endmodule

// File: rtl/irda_irq_dma_regs.sv
module irda_irq_dma_regs
  import irda_regbank_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_IRQ-1:0]  irq_evt_i,
  output logic              irq_o,
  input  logic [N_DMA-1:0]  dma_req_i,
  input  logic [N_DMA-1:0]  dma_ack_i,
  output logic [N_DMA-1:0]  dma_req_o
);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(REG_STATUS);
  localparam logic [ADDR_W-1:0] A_SET    = ADDR_W'(REG_SET);
  localparam logic [ADDR_W-1:0] A_CLR    = ADDR_W'(REG_CLR);
  localparam logic [ADDR_W-1:0] A_DMA    = ADDR_W'(REG_DMA);
  localparam int unsigned IRQ_PAD = DATA_W - N_IRQ;
  localparam int unsigned DMA_PAD = DATA_W - N_DMA;

  logic wr_set, wr_clr, wr_dma;
  logic [N_IRQ-1:0] set_vec, clr_vec, status;
  logic [N_DMA-1:0] dma_en;
  logic [DATA_W-1:0] rdata_d, rdata_q;
  logic unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:N_IRQ];

  assign wr_set = we_i && (addr_i == A_SET);
  assign wr_clr = we_i && (addr_i == A_CLR);
  assign wr_dma = we_i && (addr_i == A_DMA);

  assign set_vec = irq_evt_i | (wr_set ? wdata_i[N_IRQ-1:0] : '0);
  assign clr_vec = wr_clr ? wdata_i[N_IRQ-1:0] : '0;

  irq_status_bank #(.N(N_IRQ)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (set_vec),
    .clr_i    (clr_vec),
    .status_o (status)
  );

  assign irq_o = |status;

  for (genvar c = 0; c < N_DMA; c++) begin : g_dma
    dma_req_chan u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_wr_i    (wr_dma),
      .en_wdata_i (wdata_i[c]),
      .req_i      (dma_req_i[c]),
      .ack_i      (dma_ack_i[c]),
      .en_o       (dma_en[c]),
      .pend_o     (dma_req_o[c])
    );
  end

  always_comb begin
    unique case (addr_i)
      A_STATUS: rdata_d = {{IRQ_PAD{1'b0}}, status};
      A_DMA:    rdata_d = {{DMA_PAD{1'b0}}, dma_en};
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;

  a_r7_wo_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_SET || addr_i == A_CLR) |=> (rdata_o == '0));
  a_r12_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i > A_DMA) |=> (rdata_o == '0));
  a_r8_dma_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_DMA) |=> (rdata_o[DATA_W-1:N_DMA] == '0));
  a_r6_irq_follows_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_evt_i) |=> irq_o);
endmodule

// File: tb/tb_irda_irq_dma_regs.sv
module tb_irda_irq_dma_regs;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  irq_evt = '0;
  logic        irq;
  logic [3:0]  dreq = '0, dack = '0;
  logic [3:0]  dreq_o;
  int n_chk = 0, n_fail = 0;
  logic [31:0] rd;

  always #10 clk = ~clk;

  irda_irq_dma_regs dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .irq_evt_i(irq_evt), .irq_o(irq),
    .dma_req_i(dreq), .dma_ack_i(dack), .dma_req_o(dreq_o)
  );

  // {write addr, write data[7:0], read addr, expected read[7:0]}
  localparam logic [23:0] VEC [13] = '{
    {4'h1, 8'h01, 4'h0, 8'h01},
    {4'h1, 8'h80, 4'h0, 8'h81},
    {4'h1, 8'h00, 4'h0, 8'h81},
    {4'h2, 8'h01, 4'h0, 8'h80},
    {4'h1, 8'h3C, 4'h0, 8'hBC},
    {4'h2, 8'h00, 4'h0, 8'hBC},
    {4'h2, 8'hFF, 4'h0, 8'h00},
    {4'h1, 8'hFF, 4'h0, 8'hFF},
    {4'h2, 8'h0F, 4'h0, 8'hF0},
    {4'h2, 8'hF0, 4'h0, 8'h00},
    {4'h3, 8'h0C, 4'h3, 8'h0C},
    {4'h3, 8'hF5, 4'h3, 8'h05},
    {4'h3, 8'h00, 4'h3, 8'h00}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); addr = a; we = 1'b1; wdata = d;
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  task automatic rd_reg(logic [3:0] a, output logic [31:0] v);
    addr = a; we = 1'b0;
    @(negedge clk); v = rdata;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    rd_reg(4'h0, rd); check("R1", rd, 32'h0);
    rd_reg(4'h3, rd); check("R1", rd, 32'h0);
    check("R1", {31'b0, irq}, 32'h0);
    check("R1", {28'b0, dreq_o}, 32'h0);

    // table: R2, R3, R8 register behaviour, R6 irq line
    for (int i = 0; i < 13; i++) begin
      string tag;
      tag = (VEC[i][23:20] == 4'h1) ? "R2" : (VEC[i][23:20] == 4'h2) ? "R3" : "R8";
      wr(VEC[i][23:20], {24'hFFFFFF, VEC[i][19:12]});
      rd_reg(VEC[i][11:8], rd);
      check(tag, rd, {24'h0, VEC[i][7:0]});
      if (VEC[i][11:8] == 4'h0) check("R6", {31'b0, irq}, {31'b0, |VEC[i][7:0]});
    end

    // R7 write-only words read zero
    wr(4'h1, 32'h11);
    rd_reg(4'h1, rd); check("R7", rd, 32'h0);
    rd_reg(4'h2, rd); check("R7", rd, 32'h0);
    check("R6", {31'b0, irq}, 32'h1);
    wr(4'h2, 32'hFF);
    check("R6", {31'b0, irq}, 32'h0);

    // R4 hardware events
    @(negedge clk); irq_evt = 8'h42;
    @(negedge clk); irq_evt = 8'h00;
    check("R6", {31'b0, irq}, 32'h1);
    rd_reg(4'h0, rd); check("R4", rd, 32'h42);

    // R5 event and software clear on the same edge
    @(negedge clk); addr = 4'h2; we = 1'b1; wdata = 32'h42; irq_evt = 8'h02;
    @(negedge clk); we = 1'b0; wdata = '0; irq_evt = 8'h00;
    rd_reg(4'h0, rd); check("R5", rd, 32'h02);
    wr(4'h2, 32'hFF);

    // R12 read returns pre-edge state; unmapped word is zero
    @(negedge clk); addr = 4'h0; irq_evt = 8'h10;
    @(negedge clk); irq_evt = 8'h00; rd = rdata;
    check("R12", rd, 32'h0);
    rd_reg(4'h0, rd); check("R12", rd, 32'h10);
    rd_reg(4'hF, rd); check("R12", rd, 32'h0);
    wr(4'h2, 32'hFF);

    // DMA requests
    wr(4'h3, 32'h0F);
    @(negedge clk); dreq = 4'h3;
    @(negedge clk); dreq = 4'h0;
    check("R9", {28'b0, dreq_o}, 32'h3);
    @(negedge clk); dack = 4'h1;
    @(negedge clk); dack = 4'h0;
    check("R10", {28'b0, dreq_o}, 32'h2);
    @(negedge clk); dack = 4'h2; dreq = 4'h2;
    @(negedge clk); dack = 4'h0; dreq = 4'h0;
    check("R10", {28'b0, dreq_o}, 32'h2);
    wr(4'h3, 32'h0D);
    check("R11", {28'b0, dreq_o}, 32'h0);
    rd_reg(4'h3, rd); check("R8", rd, 32'h0D);
    @(negedge clk); dreq = 4'h2;
    @(negedge clk); dreq = 4'h0;
    check("R11", {28'b0, dreq_o}, 32'h0);
    @(negedge clk); dreq = 4'h4;
    @(negedge clk); dreq = 4'h0;
    check("R9", {28'b0, dreq_o}, 32'h4);
    // enable write and request on the same edge: old enable (0) applies
    @(negedge clk); addr = 4'h3; we = 1'b1; wdata = 32'h0F; dreq = 4'h2;
    @(negedge clk); we = 1'b0; wdata = '0; dreq = 4'h0;
    check("R9", {28'b0, dreq_o}, 32'h4);
    repeat (3) @(negedge clk);
    check("R9", {28'b0, dreq_o}, 32'h4);
    wr(4'h3, 32'h0F);
    check("R11", {28'b0, dreq_o}, 32'h4);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule